// File: doc/BRIEF.md
# Programmable CRC Calculation Unit

This block computes a cyclic redundancy check over data that software pushes through a small register bus. Four word-indexed registers are decoded: a data register, a control register, a starting-remainder register and a generator-polynomial register. Each write to the data register carries a size code: a byte, a halfword or a full word. The unit folds exactly that many input bits into a running remainder in the same clock edge. A read of the data register returns the remainder at once, so software can stream a buffer and read the result on the very next access.

The control register picks the generator width at run time (32, 16, 8 or 7 bits). It can turn on bit reversal of the incoming lanes and bit reversal of the remainder as read back. A reload bit restarts the calculation from the starting-remainder register. Any final XOR is left to software.

The control path has no sequencing beyond the configuration registers. The only state that evolves is the running remainder. It is replaced by the starting value on a reload, advanced by a data write, and held otherwise.

Top module: `crc_unit`

## Requirements
- R1: After reset the polynomial register reads 0x04C11DB7, the starting-remainder register reads 0xFFFFFFFF, the control register reads 0x38 and the data register reads 0xFFFFFFFF.
- R2: Control bits [2:1] select the generator width: 00 gives 32 bits, 01 gives 16, 10 gives 8 and 11 gives 7. The remainder follows the standard MSB-aligned division by the low N bits of the polynomial.
- R3: `bus_size` 00 feeds only `bus_wdata[7:0]` (8 bits), 01 feeds only `bus_wdata[15:0]` (16 bits), and 10 or 11 feeds all 32 bits. Unused lanes have no effect on the result.
- R4: When control bits [4:3] are not 11, the written lanes are processed from their most significant bit down to bit 0. For a word this means the upper byte goes first, MSB first.
- R5: When control bits [4:3] are 11, the bit order across the written lanes is reversed before processing. With the default configuration, byte, halfword and word writes of the same little-endian buffer give the same remainder. For the ASCII string "123456789" that remainder is 0x340BC6D9.
- R6: When control bit 5 is set, a data-register read returns the low N bits of the remainder in reversed order. When it is clear, the remainder is returned as is.
- R7: A control write with bit 0 set loads the remainder from the starting-remainder register, masked to the width written in the same access. Bit 0 always reads back as 0.
- R8: For widths below 32, the polynomial, starting-remainder and data registers read with every bit at or above N equal to 0.
- R9: A data write updates the remainder at the clock edge that accepts it. A read in the following cycle returns the new value.
- R10: The remainder is unchanged by any cycle without a write to the data or control register. This includes writes to the polynomial and starting-remainder registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register index: 0 data, 1 control, 2 starting remainder, 3 polynomial |
| bus_size | input | 2 | Data-write size: 00 byte, 01 halfword, 1x word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |

## Verification
The bench drives the published check strings through every width: CRC-32 in reflected form, CRC-16 with polynomial 0x1021, CRC-8 with polynomial 0x07 and CRC-7 with polynomial 0x09. A design that aligned the narrow generators wrongly, or took the width from the wrong control bits, would give wrong check values. The same buffer is sent as bytes, halfwords and words with junk in the unused lanes. A design that fed the wrong lane count or reversed only within bytes would give different remainders for the three forms. Output reversal is checked at 32 and 16 bits, where a 32-bit-only reversal would push a 16-bit result into the upper half. The bench also reloads after a partial stream and changes the polynomial without reloading, which exposes a reload bit that sticks or a configuration write that disturbs the remainder.

// File: rtl/crc_unit_pkg.sv
`timescale 1ns/1ps
package crc_unit_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        WID_32 = 2'b00,
        WID_16 = 2'b01,
        WID_8  = 2'b10,
        WID_7  = 2'b11
    } crc_wid_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_INIT = 2'd2,
        REG_POLY = 2'd3
    } crc_reg_e;

    // control register field positions
    localparam int CTL_RELOAD = 0;
    localparam int CTL_WID_LO = 1;
    localparam int CTL_RIN_LO = 3;
    localparam int CTL_ROUT   = 5;

    function automatic int wid_bits(crc_wid_e w);
        int n;
        unique case (w)
            WID_32:  n = 32;
            WID_16:  n = 16;
            WID_8:   n = 8;
            default: n = 7;
        endcase
        return n;
    endfunction

    function automatic logic [DW-1:0] wid_mask(crc_wid_e w);
        return {DW{1'b1}} >> (DW - wid_bits(w));
    endfunction

    function automatic int size_bits(logic [1:0] s);
        int n;
        unique case (s)
            2'b00:   n = 8;
            2'b01:   n = 16;
            default: n = 32;
        endcase
        return n;
    endfunction

    function automatic logic [DW-1:0] bit_rev(logic [DW-1:0] x);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) begin
            r[i] = x[DW-1-i];
        end
        return r;
    endfunction

    // reverse the low n bits, upper bits become zero
    function automatic logic [DW-1:0] rev_low(logic [DW-1:0] x, int n);
        return bit_rev(x) >> (DW - n);
    endfunction

endpackage

// File: rtl/crc_cfg_regs.sv
`timescale 1ns/1ps
module crc_cfg_regs
    import crc_unit_pkg::*;
#(
    parameter logic [DW-1:0] POLY_RST = 32'h04C11DB7,
    parameter logic [DW-1:0] INIT_RST = 32'hFFFFFFFF,
    parameter logic [1:0]    WID_RST  = 2'b00,
    parameter logic [1:0]    RIN_RST  = 2'b11,
    parameter logic          ROUT_RST = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] poly,
    output logic [DW-1:0] init,
    output crc_wid_e      wid,
    output logic [1:0]    rin_field,
    output logic          rout_en,
    output logic          reload
);

    logic [DW-1:0] poly_q, init_q;
    crc_wid_e      wid_q;
    logic [1:0]    rin_q;
    logic          rout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poly_q <= POLY_RST;
            init_q <= INIT_RST;
            wid_q  <= crc_wid_e'(WID_RST);
            rin_q  <= RIN_RST;
            rout_q <= ROUT_RST;
        end else if (wr_en) begin
            case (crc_reg_e'(addr))
                REG_CTRL: begin
                    wid_q  <= crc_wid_e'(wdata[CTL_WID_LO +: 2]);
                    rin_q  <= wdata[CTL_RIN_LO +: 2];
                    rout_q <= wdata[CTL_ROUT];
                end
                REG_INIT: init_q <= wdata;
                REG_POLY: poly_q <= wdata;
                default: ;
            endcase
        end
    end

    assign reload    = wr_en && (crc_reg_e'(addr) == REG_CTRL) && wdata[CTL_RELOAD];
    assign poly      = poly_q;
    assign init      = init_q;
    assign wid       = wid_q;
    assign rin_field = rin_q;
    assign rout_en   = rout_q;

endmodule

// File: rtl/crc_fold.sv
`timescale 1ns/1ps
module crc_fold
    import crc_unit_pkg::*;
(
    input  logic [DW-1:0] rem_in,
    input  logic [DW-1:0] poly,
    input  crc_wid_e      wid,
    input  logic [1:0]    size,
    input  logic          rin_en,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] rem_out
);

    int            n;
    int            nb;
    logic [DW-1:0] dsel;
    logic [DW-1:0] dal;
    logic [DW-1:0] acc;
    logic [DW-1:0] pa;
    logic          fb;

    // Remainder and generator are MSB-aligned so one bit-serial chain
    // serves every width; the chain is unrolled across the whole write.
    always_comb begin
        n    = wid_bits(wid);
        nb   = size_bits(size);
        dsel = data & ({DW{1'b1}} >> (DW - nb));
        if (rin_en) begin
            dsel = rev_low(dsel, nb);
        end
        dal  = dsel << (DW - nb);
        acc  = rem_in << (DW - n);
        pa   = poly << (DW - n);
        fb   = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < nb) begin
                fb  = acc[DW-1] ^ dal[DW-1-i];
                acc = {acc[DW-2:0], 1'b0} ^ (fb ? pa : '0);
            end
        end
        rem_out = acc >> (DW - n);
    end

endmodule

// File: rtl/crc_rd_mux.sv
`timescale 1ns/1ps
module crc_rd_mux
    import crc_unit_pkg::*;
(
    input  logic [1:0]    addr,
    input  logic [DW-1:0] rem,
    input  logic [DW-1:0] poly,
    input  logic [DW-1:0] init,
    input  crc_wid_e      wid,
    input  logic [1:0]    rin_field,
    input  logic          rout_en,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] msk;
    logic [DW-1:0] rem_m;

    always_comb begin
        msk   = wid_mask(wid);
        rem_m = rem & msk;
        unique case (crc_reg_e'(addr))
            REG_DATA: rdata = rout_en ? rev_low(rem_m, wid_bits(wid)) : rem_m;
            REG_CTRL: rdata = {{(DW-6){1'b0}}, rout_en, rin_field, wid, 1'b0};
            REG_INIT: rdata = init & msk;
            default:  rdata = poly & msk;
        endcase
    end

endmodule

// File: rtl/crc_unit.sv
`timescale 1ns/1ps
module crc_unit
    import crc_unit_pkg::*;
#(
    parameter logic [31:0] POLY_RST = 32'h04C11DB7,
    parameter logic [31:0] INIT_RST = 32'hFFFFFFFF,
    parameter logic [1:0]  WID_RST  = 2'b00,
    parameter logic [1:0]  RIN_RST  = 2'b11,
    parameter logic        ROUT_RST = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);

    logic [DW-1:0] poly_w, init_w, rem_nx, rem_q;
    crc_wid_e      wid_w;
    logic [1:0]    rin_w;
    logic          rout_w, reload_w, data_wr;

    crc_cfg_regs #(
        .POLY_RST (POLY_RST),
        .INIT_RST (INIT_RST),
        .WID_RST  (WID_RST),
        .RIN_RST  (RIN_RST),
        .ROUT_RST (ROUT_RST)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .poly      (poly_w),
        .init      (init_w),
        .wid       (wid_w),
        .rin_field (rin_w),
        .rout_en   (rout_w),
        .reload    (reload_w)
    );

    crc_fold fold_i (
        .rem_in  (rem_q),
        .poly    (poly_w),
        .wid     (wid_w),
        .size    (bus_size),
        .rin_en  (rin_w == 2'b11),
        .data    (bus_wdata),
        .rem_out (rem_nx)
    );

    assign data_wr = bus_wr && (crc_reg_e'(bus_addr) == REG_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= INIT_RST & wid_mask(crc_wid_e'(WID_RST));
        end else if (reload_w) begin
            rem_q <= init_w & wid_mask(crc_wid_e'(bus_wdata[CTL_WID_LO +: 2]));
        end else if (data_wr) begin
            rem_q <= rem_nx;
        end
    end

    crc_rd_mux rd_i (
        .addr      (bus_addr),
        .rem       (rem_q),
        .poly      (poly_w),
        .init      (init_w),
        .wid       (wid_w),
        .rin_field (rin_w),
        .rout_en   (rout_w),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/crc_unit_chk.sv
`timescale 1ns/1ps
module crc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [2:0]  wctl,
    input logic [31:0] bus_rdata,
    input logic [31:0] rem_q,
    input logic [31:0] init_w,
    input logic [1:0]  wid_w
);

    function automatic logic [31:0] msk_of(logic [1:0] w);
        logic [31:0] m;
        case (w)
            2'b00:   m = 32'hFFFFFFFF;
            2'b01:   m = 32'h0000FFFF;
            2'b10:   m = 32'h000000FF;
            default: m = 32'h0000007F;
        endcase
        return m;
    endfunction

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> $stable(rem_q));

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1 && wctl[0])
        |=> rem_q == ($past(init_w) & msk_of($past(wctl[2:1]))));

    p_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> (bus_rdata[0] == 1'b0));

    p_upper16_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_w == 2'b01 && bus_addr != 2'd1) |-> (bus_rdata[31:16] == 16'h0));

    p_upper8_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_w == 2'b10 && bus_addr != 2'd1) |-> (bus_rdata[31:8] == 24'h0));

    p_upper7_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_w == 2'b11 && bus_addr != 2'd1) |-> (bus_rdata[31:7] == 25'h0));

endmodule

bind crc_unit crc_unit_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wctl      (bus_wdata[2:0]),
    .bus_rdata (bus_rdata),
    .rem_q     (rem_q),
    .init_w    (init_w),
    .wid_w     (wid_w)
);

// File: tb/crc_unit_tb_top.sv
`timescale 1ns/1ps
module crc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_size = 2'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_INIT = 2'd2, A_POLY = 2'd3;
    localparam logic [1:0] SZ_B = 2'b00, SZ_H = 2'b01, SZ_W = 2'b10;

    always #2 clk = ~clk;

    crc_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] ctl(bit rl, logic [1:0] w, logic [1:0] ri, bit ro);
        return {26'h0, ro, ri, w, rl};
    endfunction

    // independent bit-serial model: N-bit right-aligned register
    function automatic logic [31:0] ref_fold(logic [31:0] rem, logic [31:0] poly, int n,
                                             logic [31:0] d, int nb, bit rev);
        logic [31:0] m = (n == 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 1);
        logic [31:0] dd = d;
        bit top;
        if (rev) for (int i = 0; i < nb; i++) dd[i] = d[nb-1-i];
        for (int i = nb - 1; i >= 0; i--) begin
            top = rem[n-1] ^ dd[i];
            rem = (rem << 1) & m;
            if (top) rem = rem ^ (poly & m);
        end
        return rem;
    endfunction

    function automatic logic [31:0] ref_rev(logic [31:0] x, int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = x[i];
        return r;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(A_POLY, v); chk("R1 poly", v, 32'h04C11DB7);
        rd(A_INIT, v); chk("R1 init", v, 32'hFFFFFFFF);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h00000038);
        rd(A_DATA, v); chk("R1 data", v, 32'hFFFFFFFF);
    endtask

    task automatic t_std32();
        logic [31:0] v;
        // R5 bytes with junk in upper lanes (R3)
        for (int i = 0; i < 9; i++) wr(A_DATA, SZ_B, 32'hA5C3E700 | (32'h31 + i));
        rd(A_DATA, v); chk("R5 bytes", v, 32'h340BC6D9);
        wr(A_CTRL, SZ_W, ctl(1, 2'b00, 2'b11, 1));
        rd(A_DATA, v); chk("R7 reload", v, 32'hFFFFFFFF);
        rd(A_CTRL, v); chk("R7 selfclear", v, 32'h00000038);
        wr(A_DATA, SZ_W, 32'h34333231);
        wr(A_DATA, SZ_W, 32'h38373635);
        wr(A_DATA, SZ_B, 32'hFFFFFF39);
        rd(A_DATA, v); chk("R3 words R9", v, 32'h340BC6D9);
        wr(A_CTRL, SZ_W, ctl(1, 2'b00, 2'b11, 1));
        wr(A_DATA, SZ_H, 32'hDEAD3231);
        wr(A_DATA, SZ_H, 32'hBEEF3433);
        wr(A_DATA, SZ_H, 32'h12343635);
        wr(A_DATA, SZ_H, 32'h56783837);
        wr(A_DATA, SZ_B, 32'h00000039);
        rd(A_DATA, v); chk("R3 halves", v, 32'h340BC6D9);
    endtask

    task automatic t_ccitt16();
        logic [31:0] v;
        wr(A_POLY, SZ_W, 32'hABCD1021);
        wr(A_INIT, SZ_W, 32'hFFFFFFFF);
        wr(A_CTRL, SZ_W, ctl(1, 2'b01, 2'b00, 0));
        rd(A_POLY, v); chk("R8 poly16", v, 32'h00001021);
        rd(A_INIT, v); chk("R8 init16", v, 32'h0000FFFF);
        rd(A_DATA, v); chk("R7 reload16", v, 32'h0000FFFF);
        wr(A_DATA, SZ_H, 32'hFFFF3132);
        wr(A_DATA, SZ_H, 32'h00003334);
        wr(A_DATA, SZ_H, 32'h00003536);
        wr(A_DATA, SZ_H, 32'h00003738);
        wr(A_DATA, SZ_B, 32'h00000039);
        rd(A_DATA, v); chk("R2 R4 crc16", v, 32'h000029B1);
        // R10: polynomial change without reload leaves the remainder
        wr(A_POLY, SZ_W, 32'h00008005);
        wr(A_INIT, SZ_W, 32'h00001234);
        rd(A_DATA, v); chk("R10 hold", v, 32'h000029B1);
        // R6 at 16 bits
        wr(A_CTRL, SZ_W, ctl(0, 2'b01, 2'b00, 1));
        rd(A_DATA, v); chk("R6 rev16", v, ref_rev(32'h29B1, 16));
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        wr(A_POLY, SZ_W, 32'h00000007);
        wr(A_INIT, SZ_W, 32'h00000000);
        wr(A_CTRL, SZ_W, ctl(1, 2'b10, 2'b00, 0));
        for (int i = 0; i < 9; i++) wr(A_DATA, SZ_B, 32'h31 + i);
        rd(A_DATA, v); chk("R2 crc8", v, 32'h000000F4);
        wr(A_POLY, SZ_W, 32'hFFFFFF09);
        wr(A_CTRL, SZ_W, ctl(1, 2'b11, 2'b00, 0));
        rd(A_POLY, v); chk("R8 poly7", v, 32'h00000009);
        for (int i = 0; i < 9; i++) wr(A_DATA, SZ_B, 32'h31 + i);
        rd(A_DATA, v); chk("R2 crc7", v, 32'h00000075);
    endtask

    task automatic t_revout32();
        logic [31:0] v, e;
        wr(A_POLY, SZ_W, 32'h04C11DB7);
        wr(A_INIT, SZ_W, 32'hFFFFFFFF);
        wr(A_CTRL, SZ_W, ctl(1, 2'b00, 2'b00, 1));
        wr(A_DATA, SZ_W, 32'hDEADBEEF);
        e = ref_fold(32'hFFFFFFFF, 32'h04C11DB7, 32, 32'hDEADBEEF, 32, 0);
        rd(A_DATA, v); chk("R6 R4 rev32", v, ref_rev(e, 32));
        // R5: rin field 01 is not reversal
        wr(A_CTRL, SZ_W, ctl(1, 2'b00, 2'b01, 0));
        wr(A_DATA, SZ_W, 32'hDEADBEEF);
        rd(A_DATA, v); chk("R5 rin01", v, e);
        wr(A_CTRL, SZ_W, ctl(1, 2'b00, 2'b11, 0));
        wr(A_DATA, SZ_H, 32'h0000BEEF);
        e = ref_fold(32'hFFFFFFFF, 32'h04C11DB7, 32, 32'hBEEF, 16, 1);
        rd(A_DATA, v); chk("R5 half rev", v, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_std32();
        t_ccitt16();
        t_narrow();
        t_revout32();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule